// File: doc/BRIEF.md
# Single-Bus Four-Entry ALU Datapath

This block is a compact 4-bit datapath in which every value moves over one shared bus. A small register file of four 4-bit entries is written through a write pointer and read through a separate read pointer. Neither pointer is loaded with an address. Each one is a 2-bit counter that steps forward by one when its advance pulse is given, and it wraps from 3 back to 0.

The ALU has two operands but the register file has only one read port. To get around this, a holding register first captures one operand from the read port. The ALU then combines that stored operand (A) with whatever the read port currently shows (B). A function select, a mode input and a carry input choose among sixteen logic operations and sixteen arithmetic operations, using the classic active-high 4-bit ALU function set. A 2-to-1 selector picks the value that goes back into the register file: either external data or the ALU result.

A caller runs an operation as a series of one-cycle control pulses. It loads the operands, latches the first one, points the read port at the second one, chooses the function, and then writes the result back to a chosen entry.

Top module: `sbus_alu_datapath`

## Requirements
- R1: A synchronous reset clears both pointers, the operand register and all four entries, so that `rd_val` and `op_a` read 0 after reset.
- R2: The write pointer is a 2-bit counter. It advances by one on each clock edge where `w_up` is high, and it wraps from 3 to 0.
- R3: The read pointer is an independent 2-bit counter that advances on `r_up` and wraps from 3 to 0. `rd_val` always shows the entry at the read pointer, with no clock delay.
- R4: An entry changes only on a clock edge with `w_en` high. The entry written is the one at the write pointer as it stood before that edge, even when `w_up` is high in the same cycle.
- R5: The write-back value is `data_in` when `in_sel` is 0 and `alu_f` when `in_sel` is 1.
- R6: On an edge with `l_en` high, `op_a` takes the value of `rd_val`. With `l_en` low, `op_a` keeps its value.
- R7: With `mode` = 1 the ALU does a bitwise logic function of A = `op_a` and B = `rd_val`. The functions are:
  - 0: NOT A
  - 1: NOR
  - 2: (NOT A) AND B
  - 3: 0
  - 4: NAND
  - 5: NOT B
  - 6: XOR
  - 7: A AND (NOT B)
  - 8: (NOT A) OR B
  - 9: XNOR
  - 10: B
  - 11: AND
  - 12: all ones
  - 13: A OR (NOT B)
  - 14: OR
  - 15: A

  In this mode `cin` is ignored and `cout` is held at 1.
- R8: With `mode` = 0 the ALU does the arithmetic set. Code 1001 is A plus B and code 0110 is A minus B minus 1. Any other code X plus Y is computed as a 5-bit sum. `cin` = 0 adds one more, and `cin` = 1 means no carry in. `cout` is 0 exactly when the 5-bit sum carries out of bit 3.
- R9: The add sequence works end to end. The steps are: write operand 1, read and latch it, write and read operand 2, select code 1001 with `mode` 0, then advance and write the selected ALU result. After these steps the result entry holds the 4-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 4 | External data for write-back |
| in_sel | input | 1 | Write-back source: 0 selects external data, 1 selects the ALU result |
| w_up | input | 1 | Advance the write pointer |
| w_en | input | 1 | Write the selected value at the write pointer |
| r_up | input | 1 | Advance the read pointer |
| l_en | input | 1 | Capture the read value into the operand register |
| f_sel | input | 4 | ALU function code |
| cin | input | 1 | Carry input (0 means carry) |
| mode | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| alu_f | output | 4 | ALU result |
| cout | output | 1 | Carry output (0 means carry) |
| rd_val | output | 4 | Entry at the read pointer |
| op_a | output | 4 | Stored operand A |

## Verification
The hardest case to reach from the ports is a write back of the ALU result in a cycle where the pointers are also moving. In that case the value written depends on the stored operand, the current read entry and the write pointer's old value, all at once. To reach it, the bench drives long random runs with `in_sel`, `w_up`, `w_en`, `r_up` and `l_en` all pulsed in the same cycles. A reference model tracks the entries, so every later read exposes any write that landed in the wrong place or carried the wrong value. Directed sequences cover pointer wrap-around, the full add procedure and a carry-producing sum.

// File: rtl/sbus_alu_datapath.sv
module sbus_alu_datapath #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic         in_sel,
  input  logic         w_up,
  input  logic         w_en,
  input  logic         r_up,
  input  logic         l_en,
  input  logic [3:0]   f_sel,
  input  logic         cin,
  input  logic         mode,
  output logic [W-1:0] alu_f,
  output logic         cout,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] op_a
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  xa, yb;
  logic [W:0]    sum;

  assign rd_val  = mem[rptr];
  assign wr_data = in_sel ? alu_f : data_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      op_a <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (w_en) mem[wptr] <= wr_data;
      if (w_up) wptr <= wptr + 1'b1;
      if (r_up) rptr <= rptr + 1'b1;
      if (l_en) op_a <= rd_val;
    end
  end

  assign xa = op_a | (rd_val & {W{f_sel[0]}}) | (~rd_val & {W{f_sel[1]}});
  assign yb = (op_a & ~rd_val & {W{f_sel[2]}}) | (op_a & rd_val & {W{f_sel[3]}});
  assign sum = {1'b0, xa} + {1'b0, yb} + {{W{1'b0}}, ~cin};

  assign alu_f = mode ? ~(xa ^ yb) : sum[W-1:0];
  assign cout  = mode ? 1'b1 : ~sum[W];

  // R2
  wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    w_up |=> wptr == $past(wptr) + 1'b1);
  // R2
  wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !w_up |=> $stable(wptr));
  // R3
  rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    r_up |=> rptr == $past(rptr) + 1'b1);
  // R3
  rptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !r_up |=> $stable(rptr));
  // R4
  write_land_chk: assert property (@(posedge clk) disable iff (rst)
    w_en |=> mem[$past(wptr)] == $past(wr_data));
  // R6
  latch_cap_chk: assert property (@(posedge clk) disable iff (rst)
    l_en |=> op_a == $past(rd_val));
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !l_en |=> $stable(op_a));
  // R8
  add_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode && f_sel == 4'b1001 && cin) |-> {~cout, alu_f} == ({1'b0, op_a} + {1'b0, rd_val}));

endmodule

// File: tb/sbus_alu_datapath_tb.sv
`timescale 1ns/1ps
module sbus_alu_datapath_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] data_in, f_sel;
  logic       in_sel, w_up, w_en, r_up, l_en, cin, mode;
  logic [3:0] alu_f, rd_val, op_a;
  logic       cout;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_mem [4];
  logic [1:0] m_wp, m_rp;
  logic [3:0] m_a;

  always #10 clk = ~clk;

  sbus_alu_datapath u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .in_sel(in_sel), .w_up(w_up),
    .w_en(w_en), .r_up(r_up), .l_en(l_en), .f_sel(f_sel), .cin(cin),
    .mode(mode), .alu_f(alu_f), .cout(cout), .rd_val(rd_val), .op_a(op_a)
  );

  function automatic logic [4:0] alu_ref(input logic [3:0] s, input logic m, input logic c,
                                         input logic [3:0] a, input logic [3:0] b);
    logic [3:0] f;
    logic [4:0] r, k;
    k = c ? 5'd0 : 5'd1;
    if (m) begin
      case (s)
        4'd0:  f = ~a;
        4'd1:  f = ~(a | b);
        4'd2:  f = ~a & b;
        4'd3:  f = 4'h0;
        4'd4:  f = ~(a & b);
        4'd5:  f = ~b;
        4'd6:  f = a ^ b;
        4'd7:  f = a & ~b;
        4'd8:  f = ~a | b;
        4'd9:  f = ~(a ^ b);
        4'd10: f = b;
        4'd11: f = a & b;
        4'd12: f = 4'hF;
        4'd13: f = a | ~b;
        4'd14: f = a | b;
        default: f = a;
      endcase
      return {1'b1, f};
    end
    case (s)
      4'd0:  r = {1'b0, a} + k;
      4'd1:  r = {1'b0, a | b} + k;
      4'd2:  r = {1'b0, a | ~b} + k;
      4'd3:  r = 5'h0F + k;
      4'd4:  r = {1'b0, a} + {1'b0, a & ~b} + k;
      4'd5:  r = {1'b0, a | b} + {1'b0, a & ~b} + k;
      4'd6:  r = {1'b0, a} + {1'b0, ~b} + k;
      4'd7:  r = {1'b0, a & ~b} + 5'h0F + k;
      4'd8:  r = {1'b0, a} + {1'b0, a & b} + k;
      4'd9:  r = {1'b0, a} + {1'b0, b} + k;
      4'd10: r = {1'b0, a | ~b} + {1'b0, a & b} + k;
      4'd11: r = {1'b0, a & b} + 5'h0F + k;
      4'd12: r = {1'b0, a} + {1'b0, a} + k;
      4'd13: r = {1'b0, a | b} + {1'b0, a} + k;
      4'd14: r = {1'b0, a | ~b} + {1'b0, a} + k;
      default: r = {1'b0, a} + 5'h0F + k;
    endcase
    return {~r[4], r[3:0]};
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    in_sel = 0; w_up = 0; w_en = 0; r_up = 0; l_en = 0;
  endtask

  // Drive at negedge, compare against model, step model at posedge.
  task automatic cyc(input logic [3:0] d, input logic is, wu, we, ru, le,
                     input logic [3:0] fs, input logic c, m);
    logic [4:0] ex;
    logic [3:0] wd;
    data_in = d; in_sel = is; w_up = wu; w_en = we; r_up = ru; l_en = le;
    f_sel = fs; cin = c; mode = m;
    #2;
    ex = alu_ref(fs, m, c, m_a, m_mem[m_rp]);
    check("R3 rd_val", {1'b0, rd_val}, {1'b0, m_mem[m_rp]});
    check("R6 op_a", {1'b0, op_a}, {1'b0, m_a});
    check(m ? "R7 logic alu" : "R8 arith alu", {cout, alu_f}, ex);
    wd = is ? ex[3:0] : d;
    @(posedge clk);
    if (le) m_a = m_mem[m_rp];
    if (we) m_mem[m_wp] = wd;
    if (wu) m_wp = m_wp + 2'd1;
    if (ru) m_rp = m_rp + 2'd1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0A1B);
    idle(); data_in = 0; f_sel = 0; cin = 1; mode = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < 4; i++) m_mem[i] = 4'h0;
    m_wp = 0; m_rp = 0; m_a = 0;
    // R1 reset state
    check("R1 rd_val after reset", {1'b0, rd_val}, 5'h00);
    check("R1 op_a after reset", {1'b0, op_a}, 5'h00);

    // R9 add sequence: 3 + 5 into entry 3
    cyc(4'd3, 0, 1, 0, 0, 0, 4'd0, 1, 1);
    cyc(4'd3, 0, 0, 1, 0, 0, 4'd0, 1, 1);
    cyc(4'd0, 0, 0, 0, 1, 0, 4'd0, 1, 1);
    cyc(4'd0, 0, 0, 0, 0, 1, 4'd0, 1, 1);
    cyc(4'd5, 0, 1, 0, 0, 0, 4'd0, 1, 1);
    cyc(4'd5, 0, 0, 1, 0, 0, 4'd0, 1, 1);
    cyc(4'd0, 0, 0, 0, 1, 0, 4'd9, 1, 0);
    check("R8 add 3+5", {cout, alu_f}, {1'b1, 4'd8});
    cyc(4'd0, 1, 1, 0, 0, 0, 4'd9, 1, 0);
    cyc(4'd0, 1, 0, 1, 0, 0, 4'd9, 1, 0);
    cyc(4'd0, 0, 0, 0, 1, 0, 4'd9, 1, 0);
    check("R9 stored sum", {1'b0, rd_val}, 5'd8);
    check("R5 write-back of ALU result", {1'b0, rd_val}, {1'b0, 4'd8});

    // R2 and R3 wrap: write 5 values with w_up in the same cycle (R4 old pointer)
    for (int i = 0; i < 5; i++) cyc(4'(4'hA + i), 0, 1, 1, 0, 0, 4'd0, 1, 1);
    // writes went to 3,0,1,2,3; entry 3 ends as E
    check("R2 write pointer wrap", {1'b0, rd_val}, {1'b0, 4'hE});
    cyc(4'd0, 0, 0, 0, 1, 0, 4'd0, 1, 1);
    check("R3 read pointer wrap to 0", {1'b0, rd_val}, {1'b0, 4'hB});
    cyc(4'd0, 0, 0, 0, 0, 1, 4'd0, 1, 1);
    check("R6 latched value", {1'b0, op_a}, {1'b0, 4'hB});
    // R4 no write without w_en
    cyc(4'h1, 0, 0, 0, 0, 0, 4'd0, 1, 1);
    check("R4 no write without w_en", {1'b0, rd_val}, {1'b0, 4'hB});

    // R8 carry: B + B = 11+11 = 22 -> 6 with carry (cout 0)
    cyc(4'd0, 0, 0, 0, 0, 0, 4'd9, 1, 0);
    check("R8 carry out on 11+11", {cout, alu_f}, {1'b0, 4'h6});
    // R7 logic ignores cin
    cyc(4'd0, 0, 0, 0, 0, 0, 4'd6, 0, 1);
    check("R7 xor ignores cin", {cout, alu_f}, {1'b1, 4'h0});

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(4'($urandom), r[0], r[1] & r[2], r[3], r[4] & r[5], r[6] & r[7],
          4'($urandom), r[8], r[9]);
    end

    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule